// File: doc/BRIEF.md
# Interrupt Vectoring Unit

This block sits beside an 8051-style CPU core and decides when the core may break into its instruction stream with a hardware long-call. On each machine-cycle tick it captures the request lines into flags. Edge-type sources keep their flag until the call is acknowledged. Level-type sources follow their line. At each poll the unit chooses one winner among the flags that are enabled and that outrank every priority level already in service. It then raises a call request together with the 16-bit vector address of the winning source.

The core acknowledges the call when it starts the long-call sequence. Stacking the program counter is the core's job, and the status word is not saved. On acknowledge the unit marks the winner's level as in service. Only a completed return-from-interrupt instruction releases a level, and it releases the highest one only, so an interrupted lower-level routine becomes the active level again. A plain return has no port and cannot release anything.

Polling takes place only in the last cycle of an instruction. It is also skipped when that instruction is a return-from-interrupt or touches the enable or priority registers. As a result, at least one more instruction completes before a vector is taken.

Top module: `irqv_unit`

## Requirements
- R1: Request lines are sampled only at clock edges where `mc_tick` is 1. A level-type source's flag equals its line at the latest tick. An edge-type source's flag sets when the line is 1 at a tick and was 0 at the previous tick. A pulse that starts and ends between ticks is never seen.
- R2: `call_req` can rise only at an edge where `mc_tick`=1, `instr_last`=1, `reti_exec`=0 and `sfr_access`=0. Mid-instruction cycles, return-from-interrupt instructions and enable/priority register accesses all hold service off.
- R3: A source is eligible only if its flag is set, `en_global`=1, its `en_src` bit is 1, and its level is strictly above the highest level in `in_service` (or `in_service` is 0).
- R4: A source's level is {`pri_hi`[i], `pri_lo`[i]}, from 0 to 3, with 3 the highest. The highest eligible level wins. Among sources of equal level, the lowest index wins.
- R5: `call_vec` = 0x0003 + 8 × winning source index.
- R6: Once raised, `call_req` stays 1 with `call_vec` unchanged until an edge with `call_ack`=1. It is 0 after that edge, and no new poll happens while it is 1.
- R7: An edge with `call_ack`=1 and `call_req`=1 sets `in_service` bit L, where L is the winner's level. It also clears the winner's flag if that source is edge-type.
- R8: An edge with `mc_tick`, `instr_last` and `reti_exec` all 1 clears only the highest set bit of `in_service`. No other input clears any bit.
- R9: If a line rises before tick k and nothing blocks it, `call_req` is 1 after tick k+1 and 0 after tick k.
- R10: After reset, `call_req` is 0, `in_service` is 0 and all flags are clear.
- R11: A level-type request whose line drops before it can be polled is not serviced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mc_tick | input | 1 | Machine-cycle strobe |
| instr_last | input | 1 | Current machine cycle is the last of the instruction |
| reti_exec | input | 1 | Instruction executing is return-from-interrupt |
| sfr_access | input | 1 | Instruction reads or writes enable/priority registers |
| call_ack | input | 1 | Core starts the long-call for the pending vector |
| irq_raw | input | NUM_SRC | Request lines |
| edge_mode | input | NUM_SRC | 1 = edge-type source, 0 = level-type |
| en_global | input | 1 | Global interrupt enable |
| en_src | input | NUM_SRC | Per-source enable |
| pri_lo | input | NUM_SRC | Priority level bit 0 per source |
| pri_hi | input | NUM_SRC | Priority level bit 1 per source |
| call_req | output | 1 | Long-call request to the core |
| call_vec | output | 16 | Vector address for the pending call |
| in_service | output | 4 | In-service marker per priority level |

## Verification
Flags update at a tick edge, and `call_req` with `call_vec` follows at the next polling edge. A line raised before one tick therefore shows up on `call_req` only after the second tick. `in_service` changes at the edge that carries an acknowledge or a completed return-from-interrupt. The bench's reference model advances at each rising edge from the inputs held since the previous falling edge and is compared one time unit later. Directed checks sample at falling edges, after a known number of rising edges.

// File: rtl/irqv_pkg.sv
package irqv_pkg;
    localparam int LVL_W = 2;
    localparam int N_LVL = 4;
    typedef logic [LVL_W-1:0] lvl_t;
endpackage

// File: rtl/irqv_flag_latch.sv
module irqv_flag_latch #(
    parameter int N = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic [N-1:0] raw,
    input  logic [N-1:0] edge_mode,
    input  logic [N-1:0] clr,
    output logic [N-1:0] flag_q
);
    typedef struct packed {
        logic [N-1:0] flag;
        logic [N-1:0] prev;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (tick) begin
            st_d.prev = raw;
            st_d.flag = (edge_mode & (st_q.flag | (raw & ~st_q.prev)))
                      | (~edge_mode & raw);
        end
        st_d.flag = st_d.flag & ~(clr & edge_mode);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flag_q = st_q.flag;

    // R1: without a tick and without a clear, flags do not move
    a_r1_hold_between_ticks: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && clr == '0) |=> flag_q == $past(flag_q));

    // R7: acknowledged edge-type source is cleared
    a_r7_ack_clears_edge: assert property (@(posedge clk) disable iff (!rst_n)
        ((clr & edge_mode) != '0) |=> ((flag_q & $past(clr & edge_mode)) == '0));
endmodule

// File: rtl/irqv_arbiter.sv
module irqv_arbiter
    import irqv_pkg::*;
#(
    parameter int N     = 6,
    parameter int IDX_W = 3
) (
    input  logic [N-1:0]     flag,
    input  logic [N-1:0]     en_src,
    input  logic             en_global,
    input  logic [N-1:0]     pri_lo,
    input  logic [N-1:0]     pri_hi,
    input  logic             ceil_valid,
    input  lvl_t             ceil_lvl,
    output logic             found,
    output logic [IDX_W-1:0] win_idx,
    output lvl_t             win_lvl
);
    lvl_t cand_lvl;
    logic cand_ok;

    always_comb begin
        found    = 1'b0;
        win_idx  = '0;
        win_lvl  = '0;
        cand_lvl = '0;
        cand_ok  = 1'b0;
        for (int i = 0; i < N; i++) begin
            cand_lvl = {pri_hi[i], pri_lo[i]};
            cand_ok  = en_global && en_src[i] && flag[i]
                       && (!ceil_valid || cand_lvl > ceil_lvl);
            // strict compare keeps the lowest index among equal levels
            if (cand_ok && (!found || cand_lvl > win_lvl)) begin
                found   = 1'b1;
                win_idx = IDX_W'(i);
                win_lvl = cand_lvl;
            end
        end
    end
endmodule

// File: rtl/irqv_level_stack.sv
module irqv_level_stack
    import irqv_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  lvl_t             push_lvl,
    input  logic             pop,
    output logic [N_LVL-1:0] inprog_q,
    output logic             top_valid,
    output lvl_t             top_lvl
);
    logic [N_LVL-1:0] inprog_d;

    always_comb begin
        top_valid = 1'b0;
        top_lvl   = '0;
        for (int l = 0; l < N_LVL; l++) begin
            if (inprog_q[l]) begin
                top_valid = 1'b1;
                top_lvl   = lvl_t'(l);
            end
        end
    end

    always_comb begin
        inprog_d = inprog_q;
        if (pop && top_valid) inprog_d[top_lvl] = 1'b0;
        if (push)             inprog_d[push_lvl] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) inprog_q <= '0;
        else        inprog_q <= inprog_d;
    end

    // R8: a return releases exactly one level
    a_r8_pop_single: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push && inprog_q != '0) |=>
            ($countones(inprog_q) + 1 == $countones($past(inprog_q))));

    // R8: nothing but a return clears a level
    a_r8_only_reti_clears: assert property (@(posedge clk) disable iff (!rst_n)
        !pop |=> ((inprog_q & $past(inprog_q)) == $past(inprog_q)));

    // R7: acknowledge marks the level
    a_r7_push_sets: assert property (@(posedge clk) disable iff (!rst_n)
        push |=> inprog_q[$past(push_lvl)]);
endmodule

// File: rtl/irqv_unit.sv
module irqv_unit
    import irqv_pkg::*;
#(
    parameter int          NUM_SRC  = 6,
    parameter logic [15:0] VEC_BASE = 16'h0003,
    parameter int          VEC_STEP = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               mc_tick,
    input  logic               instr_last,
    input  logic               reti_exec,
    input  logic               sfr_access,
    input  logic               call_ack,
    input  logic [NUM_SRC-1:0] irq_raw,
    input  logic [NUM_SRC-1:0] edge_mode,
    input  logic               en_global,
    input  logic [NUM_SRC-1:0] en_src,
    input  logic [NUM_SRC-1:0] pri_lo,
    input  logic [NUM_SRC-1:0] pri_hi,
    output logic               call_req,
    output logic [15:0]        call_vec,
    output logic [N_LVL-1:0]   in_service
);
    localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

    typedef struct packed {
        logic             req;
        logic [IDX_W-1:0] idx;
        lvl_t             lvl;
        logic [15:0]      vec;
    } st_t;

    st_t st_d, st_q;

    logic [NUM_SRC-1:0] flag;
    logic [NUM_SRC-1:0] clr;
    logic               found;
    logic [IDX_W-1:0]   win_idx;
    lvl_t               win_lvl;
    logic               top_valid;
    lvl_t               top_lvl;
    logic               push;
    logic               pop;
    logic               poll_ok;

    assign push    = call_ack && st_q.req;
    assign pop     = mc_tick && instr_last && reti_exec;
    assign poll_ok = mc_tick && instr_last && !reti_exec && !sfr_access && !st_q.req;

    always_comb begin
        clr = '0;
        if (push) clr[st_q.idx] = 1'b1;
    end

    irqv_flag_latch #(.N(NUM_SRC)) u_latch (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (mc_tick),
        .raw       (irq_raw),
        .edge_mode (edge_mode),
        .clr       (clr),
        .flag_q    (flag)
    );

    irqv_arbiter #(.N(NUM_SRC), .IDX_W(IDX_W)) u_arb (
        .flag       (flag),
        .en_src     (en_src),
        .en_global  (en_global),
        .pri_lo     (pri_lo),
        .pri_hi     (pri_hi),
        .ceil_valid (top_valid),
        .ceil_lvl   (top_lvl),
        .found      (found),
        .win_idx    (win_idx),
        .win_lvl    (win_lvl)
    );

    irqv_level_stack u_stack (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push),
        .push_lvl  (st_q.lvl),
        .pop       (pop),
        .inprog_q  (in_service),
        .top_valid (top_valid),
        .top_lvl   (top_lvl)
    );

    always_comb begin
        st_d = st_q;
        if (push) begin
            st_d.req = 1'b0;
        end else if (poll_ok && found) begin
            st_d.req = 1'b1;
            st_d.idx = win_idx;
            st_d.lvl = win_lvl;
            st_d.vec = VEC_BASE + 16'(VEC_STEP) * 16'(win_idx);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign call_req = st_q.req;
    assign call_vec = st_q.vec;

    // R2: a call starts only at an unblocked instruction boundary
    a_r2_boundary_only: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(call_req) |-> $past(mc_tick && instr_last && !reti_exec && !sfr_access));

    // R6: request and vector held until acknowledge
    a_r6_hold_until_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (call_req && !call_ack) |=> (call_req && $stable(call_vec)));

    // R6: acknowledge drops the request
    a_r6_ack_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (call_req && call_ack) |=> !call_req);

    // R3: pending call outranks every level in service
    a_r3_above_ceiling: assert property (@(posedge clk) disable iff (!rst_n)
        call_req |-> (!top_valid || st_q.lvl > top_lvl));
endmodule

// File: tb/irqv_unit_test.sv
module irqv_unit_test;
    localparam int CLK_PERIOD = 10;
    localparam int NS = 6;
    localparam int WATCHDOG = 100000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          mc_tick = 1'b1, instr_last = 1'b1, reti_exec = 1'b0;
    logic          sfr_access = 1'b0, call_ack = 1'b0, en_global = 1'b1;
    logic [NS-1:0] irq_raw = '0, edge_mode = 6'b001111, en_src = '1;
    logic [NS-1:0] pri_lo = '0, pri_hi = '0;
    logic          call_req;
    logic [15:0]   call_vec;
    logic [3:0]    in_service;

    int unsigned checks = 0, failures = 0, cycles = 0;
    int unsigned seed_v;

    irqv_unit uut (
        .clk(clk), .rst_n(rst_n), .mc_tick(mc_tick), .instr_last(instr_last),
        .reti_exec(reti_exec), .sfr_access(sfr_access), .call_ack(call_ack),
        .irq_raw(irq_raw), .edge_mode(edge_mode), .en_global(en_global),
        .en_src(en_src), .pri_lo(pri_lo), .pri_hi(pri_hi),
        .call_req(call_req), .call_vec(call_vec), .in_service(in_service)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [15:0] vec_of(input int i);
        return 16'(3 + 8 * i);
    endfunction

    function automatic logic [3:0] drop_top(input logic [3:0] v);
        logic [3:0] r = v;
        for (int l = 3; l >= 0; l--) if (v[l]) begin r[l] = 1'b0; break; end
        return r;
    endfunction

    function automatic bit pick(input logic [NS-1:0] fl, input logic [3:0] inp,
                                output int idx, output int lvl);
        int top = -1;
        bit hit = 0;
        idx = 0; lvl = 0;
        for (int l = 0; l < 4; l++) if (inp[l]) top = l;
        for (int i = 0; i < NS; i++) begin
            int lv = {pri_hi[i], pri_lo[i]};
            if (en_global && en_src[i] && fl[i] && lv > top && (!hit || lv > lvl)) begin
                hit = 1; idx = i; lvl = lv;
            end
        end
        return hit;
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] got,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, got, exp);
        end
    endtask

    // reference model
    logic [NS-1:0] m_flag, m_prev;
    logic [3:0]    m_inp;
    logic          m_req;
    logic [15:0]   m_vec;
    int            m_idx, m_lvl;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_flag = '0; m_prev = '0; m_inp = '0; m_req = 0; m_vec = '0;
            m_idx = 0; m_lvl = 0;
        end else begin
            logic [NS-1:0] n_flag = m_flag;
            logic [3:0]    n_inp = m_inp;
            int w_idx, w_lvl;
            bit hit;
            hit = pick(m_flag, m_inp, w_idx, w_lvl);
            if (mc_tick) begin
                n_flag = (edge_mode & (m_flag | (irq_raw & ~m_prev))) | (~edge_mode & irq_raw);
                m_prev = irq_raw;
            end
            if (mc_tick && instr_last && reti_exec) n_inp = drop_top(m_inp);
            if (call_ack && m_req) begin
                n_inp[m_lvl] = 1'b1;
                if (edge_mode[m_idx]) n_flag[m_idx] = 1'b0;
                m_req = 0;
            end else if (!m_req && mc_tick && instr_last && !reti_exec && !sfr_access && hit) begin
                m_req = 1; m_idx = w_idx; m_lvl = w_lvl; m_vec = vec_of(w_idx);
            end
            m_flag = n_flag;
            m_inp = n_inp;
        end
        #1;
        if (rst_n) begin
            check(call_req === m_req, "R2 call_req vs model", 32'(call_req), 32'(m_req));
            if (m_req) check(call_vec === m_vec, "R5 call_vec vs model", 32'(call_vec), 32'(m_vec));
            check(in_service === m_inp, "R8 in_service vs model", 32'(in_service), 32'(m_inp));
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask
    task automatic do_ack();
        call_ack = 1; step(1); call_ack = 0;
    endtask
    task automatic do_reti();
        reti_exec = 1; step(1); reti_exec = 0;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected<=%0d", cycles, WATCHDOG);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        seed_v = $urandom(32'd4051);
        step(3);
        rst_n = 1;
        step(1);
        check(call_req == 0, "R10 call_req after reset", 32'(call_req), 0);
        check(in_service == 0, "R10 in_service after reset", 32'(in_service), 0);

        // R9 latency, R5 vector
        irq_raw[1] = 1; step(1);
        check(call_req == 0, "R9 not yet after first tick", 32'(call_req), 0);
        step(1);
        check(call_req == 1, "R9 request after second tick", 32'(call_req), 1);
        check(call_vec == vec_of(1), "R5 vector src1", 32'(call_vec), 32'(vec_of(1)));
        irq_raw[1] = 0; step(2);
        check(call_req == 1 && call_vec == vec_of(1), "R6 held without ack", 32'(call_vec), 32'(vec_of(1)));
        do_ack();
        check(call_req == 0, "R6 dropped after ack", 32'(call_req), 0);
        check(in_service == 4'b0001, "R7 level 0 marked", 32'(in_service), 1);

        // R3 same level blocked, R8 RET has no effect, RETI releases
        irq_raw[0] = 1; step(4);
        check(call_req == 0, "R3 same level blocked", 32'(call_req), 0);
        check(in_service == 4'b0001, "R8 no release without RETI", 32'(in_service), 1);
        do_reti();
        check(in_service == 0, "R8 RETI releases", 32'(in_service), 0);
        check(call_req == 0, "R2 RETI instruction blocks poll", 32'(call_req), 0);
        step(1);
        check(call_req == 1 && call_vec == vec_of(0), "R2 poll after next instruction", 32'(call_vec), 32'(vec_of(0)));
        irq_raw[0] = 0; do_ack(); do_reti();

        // R1 pulse between ticks unseen
        mc_tick = 0; irq_raw[2] = 1; step(1); irq_raw[2] = 0; step(2);
        mc_tick = 1; step(3);
        check(call_req == 0, "R1 pulse between ticks ignored", 32'(call_req), 0);

        // R4 equal level, lowest index first
        pri_lo = 6'b001100; irq_raw[3] = 1; irq_raw[2] = 1; step(2);
        check(call_req == 1 && call_vec == vec_of(2), "R4 tie lowest index", 32'(call_vec), 32'(vec_of(2)));
        do_ack(); irq_raw[3:2] = 2'b00;
        check(in_service == 4'b0010, "R7 level 1 marked", 32'(in_service), 2);
        do_reti(); step(1);
        check(call_req == 1 && call_vec == vec_of(3), "R4 latched peer served next", 32'(call_vec), 32'(vec_of(3)));
        do_ack(); do_reti(); pri_lo = '0;

        // R8 nesting: level 2 then level 3 preempts
        pri_hi = 6'b110000; pri_lo = 6'b010000;
        irq_raw[5] = 1; step(2);
        check(call_req == 1 && call_vec == vec_of(5), "R4 level 2 served", 32'(call_vec), 32'(vec_of(5)));
        do_ack(); irq_raw[5] = 0;
        irq_raw[4] = 1; step(2);
        check(call_req == 1 && call_vec == vec_of(4), "R3 higher level preempts", 32'(call_vec), 32'(vec_of(4)));
        do_ack(); irq_raw[4] = 0;
        check(in_service == 4'b1100, "R7 nested levels", 32'(in_service), 12);
        do_reti();
        check(in_service == 4'b0100, "R8 only top released", 32'(in_service), 4);
        do_reti();
        check(in_service == 0, "R8 second release", 32'(in_service), 0);
        pri_hi = '0; pri_lo = '0;

        // R2 mid-instruction hold
        instr_last = 0; irq_raw[1] = 1; step(3);
        check(call_req == 0, "R2 mid-instruction blocked", 32'(call_req), 0);
        instr_last = 1; step(1);
        check(call_req == 1 && call_vec == vec_of(1), "R2 served at last cycle", 32'(call_vec), 32'(vec_of(1)));
        irq_raw[1] = 0; do_ack(); do_reti();

        // R2 register access hold
        sfr_access = 1; irq_raw[2] = 1; step(2);
        check(call_req == 0, "R2 register access blocks", 32'(call_req), 0);
        sfr_access = 0; step(1);
        check(call_req == 1 && call_vec == vec_of(2), "R2 served after access", 32'(call_vec), 32'(vec_of(2)));
        irq_raw[2] = 0; do_ack(); do_reti();

        // R11 dropped level request
        instr_last = 0; irq_raw[4] = 1; step(2); irq_raw[4] = 0; step(1);
        instr_last = 1; step(2);
        check(call_req == 0, "R11 dropped request not served", 32'(call_req), 0);

        // R3 global enable
        en_global = 0; irq_raw[5] = 1; step(3);
        check(call_req == 0, "R3 global disable", 32'(call_req), 0);
        en_global = 1; step(1);
        check(call_req == 1 && call_vec == vec_of(5), "R3 served when enabled", 32'(call_vec), 32'(vec_of(5)));
        irq_raw[5] = 0; do_ack(); do_reti();

        // random phase, checked against the model
        for (int k = 0; k < 3000; k++) begin
            mc_tick    = ($urandom % 4) != 0;
            instr_last = ($urandom % 2) == 0;
            reti_exec  = instr_last && (($urandom % 6) == 0);
            sfr_access = ($urandom % 8) == 0;
            call_ack   = call_req && (($urandom % 2) == 0);
            irq_raw    = NS'($urandom);
            en_global  = ($urandom % 8) != 0;
            en_src     = NS'($urandom);
            pri_lo     = NS'($urandom);
            pri_hi     = NS'($urandom);
            step(1);
        end
        step(2);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule